// File: doc/BRIEF.md
# Asynchronous serial receive deframer

This block turns an asynchronous serial line into characters for a receive FIFO. It is driven by the system clock and a one-cycle enable that pulses at sixteen times the bit rate. The enable comes from a baud divider outside the block. A falling line starts a candidate frame. The block confirms the start at the middle of the start bit. It then samples each data bit, an optional parity bit and the stop bits at their centres. When the character completes, the block presents the character and its error flags to the FIFO with a one-cycle write strobe.

The line format is set by three static inputs: the character width, the stop-bit selection and the parity mode. The FIFO is seen only as a full flag. When a character completes while the FIFO is full, the block pulses an overrun indication and writes nothing, so the stored characters are untouched. A loopback select takes the serial input from the local transmitter instead of the pin. A pulse at each character's stop-bit centre is provided for an external receive time-out counter.

Top module: `uart_rx_deframer`

## Requirements
- R1: After a synchronous active-low reset, wr_stb, overrun and stop_mid are low, and they stay low while the line idles high.
- R2: A low line detected on a tick is sampled again OS_RATE/2 ticks later. If it is high by then, the start is dropped and no character, overrun or stop_mid pulse follows.
- R3: Each data bit is sampled OS_RATE ticks after the previous sample. Bits arrive least significant first and are placed in wr_data from bit 0 upward. Unused upper bits read zero.
- R4: word_len selects the character width: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8.
- R5: With stop_sel low, one stop bit is checked. With stop_sel high and 5-bit characters (1.5 stop bits), only the first stop bit is checked. With stop_sel high and 6 to 8 bits, both stop bits are checked. The character completes at the centre of the last checked stop bit.
- R6: par_cfg[0] high enables a parity bit. par_cfg[2] low gives computed parity: par_cfg[1]=0 means odd, par_cfg[1]=1 means even. par_cfg[2] high forces the expected bit to the inverse of par_cfg[1], so 101 expects 1 and 111 expects 0. wr_perr is set when the received parity bit differs from the expected one.
- R7: wr_ferr is set when any checked stop bit is sampled low.
- R8: A frame whose every sampled bit is low is written once with wr_brk=1, wr_ferr=1 and wr_data=0. No further character starts until the line is seen high on a tick.
- R9: If fifo_full is high when a character completes, overrun pulses for one cycle and wr_stb stays low.
- R10: stop_mid pulses for one cycle at every character completion, whether the character is written, overrun, in error or a break.
- R11: With loop_en high, the line is taken from loop_tx and rx_pin has no effect.
- R12: Sampling advances only on cycles with tick16 high. The line passes through SYNC_STAGES flops. Output pulses appear in the cycle after the completing tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | Oversampling enable, OS_RATE per bit |
| rx_pin | input | 1 | Serial line from the pin, idle high |
| loop_tx | input | 1 | Local transmitter serial output |
| loop_en | input | 1 | Take the line from loop_tx |
| word_len | input | 2 | Character width code |
| stop_sel | input | 1 | Extended stop-bit selection |
| par_cfg | input | 3 | Parity enable, even select, stick select |
| fifo_full | input | 1 | Receive FIFO cannot accept a write |
| wr_stb | output | 1 | One-cycle write into the FIFO |
| wr_data | output | 8 | Received character |
| wr_perr | output | 1 | Parity error for the character |
| wr_ferr | output | 1 | Framing error for the character |
| wr_brk | output | 1 | Break character |
| overrun | output | 1 | Character lost because the FIFO was full |
| stop_mid | output | 1 | Stop-bit centre pulse per character |

## Verification
The bench uses the default OS_RATE of 16 and SYNC_STAGES of 2. It keeps tick16 high on every clock, so each bit lasts exactly 16 cycles. This lets the bench predict the completion cycle of every frame from the cycle in which it drives the start edge, and compare the outputs on every clock. With tick16 dropped for 30 cycles in the middle of a frame, the same prediction shifted by 30 checks that sampling follows the enable and not the clock. The two-flop synchronizer and the short frames also make false starts, break hold-off and the restart after a framing error all occur within a few hundred cycles.

// File: rtl/rxdf_pkg.sv
// Shared types and helpers for the receive deframer.
// Assumes characters of 5 to 8 bits held in an 8-bit field.
package rxdf_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRKW
    } rx_state_t;

    // Character width from the two-bit width code.
    function automatic logic [3:0] data_bits(input logic [1:0] wl);
        return 4'd5 + {2'b00, wl};
    endfunction

    // Parity bit the receiver expects for a given character.
    function automatic logic expect_parity(input logic [DATA_W-1:0] d,
                                           input logic even_sel,
                                           input logic stick);
        if (stick)
            return ~even_sel;
        else
            return even_sel ? ^d : ~^d;
    endfunction

endpackage

// File: rtl/rxdf_line_in.sv
// Line input stage: selects pin or loopback source and synchronizes it.
// Assumes the selected source idles high; the chain resets to high.
module rxdf_line_in #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pin,
    input  logic loop_tx,
    input  logic loop_en,
    output logic line_sync
);

    logic                   chosen;
    logic [SYNC_STAGES-1:0] sync_q;

    // Source select between the pin and the local transmitter.
    assign chosen = loop_en ? loop_tx : rx_pin;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First flop captures the selected source.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b1;
                else        sync_q[g] <= chosen;
            end
        end else begin : g_next
            // Later flops extend the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b1;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign line_sync = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/rxdf_bit_timer.sv
// Oversample counter: fires a sample pulse at half a bit (start check)
// or a full bit after the previous sample. Counts only on tick cycles.
// Assumes OS_RATE is even and at least 4.
module rxdf_bit_timer #(
    parameter int OS_RATE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold,
    input  logic half_sel,
    output logic sample
);

    localparam int CW   = $clog2(OS_RATE);
    localparam int HALF = OS_RATE / 2;

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // Interval end selected by the caller's phase.
    assign limit  = half_sel ? CW'(HALF - 1) : CW'(OS_RATE - 1);
    assign sample = tick && !hold && (cnt == limit);

    // Tick counter, cleared while held and after each sample.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) cnt <= '0;
        else if (sample)    cnt <= '0;
        else if (tick)      cnt <= cnt + 1'b1;
    end

    // R12
    cnt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !hold) |=> $stable(cnt));

endmodule

// File: rtl/rxdf_frame_fsm.sv
// Frame state machine: validates the start bit, collects data, parity and
// stop bits on timer samples, and issues the FIFO write or overrun.
// Assumes the line is already synchronized and format inputs are static
// while a frame is in progress.
module rxdf_frame_fsm
    import rxdf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              samp,
    input  logic [1:0]        word_len,
    input  logic              stop_sel,
    input  logic [2:0]        par_cfg,
    input  logic              fifo_full,
    output logic              timer_hold,
    output logic              timer_half,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_perr,
    output logic              wr_ferr,
    output logic              wr_brk,
    output logic              overrun,
    output logic              stop_mid
);

    rx_state_t         state;
    logic [2:0]        bidx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              all_low;
    logic              ferr_acc;
    logic              stop_idx;

    logic [3:0] nbits;
    logic       last_data;
    logic       two_stop;
    logic       last_stop;
    logic       ferr_n;
    logic       low_n;
    logic       perr_n;

    assign timer_hold = (state == ST_IDLE) || (state == ST_BRKW);
    assign timer_half = (state == ST_START);

    // Per-sample decisions for the current frame position.
    always_comb begin
        nbits     = data_bits(word_len);
        last_data = ({1'b0, bidx} == nbits - 4'd1);
        two_stop  = stop_sel && (word_len != 2'b00);
        last_stop = !two_stop || stop_idx;
        ferr_n    = ferr_acc | ~line;
        low_n     = all_low & ~line;
        perr_n    = par_cfg[0] &&
                    (par_bit != expect_parity(shreg, par_cfg[1], par_cfg[2]));
    end

    // Frame sequencing and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bidx     <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            all_low  <= 1'b1;
            ferr_acc <= 1'b0;
            stop_idx <= 1'b0;
            wr_stb   <= 1'b0;
            wr_data  <= '0;
            wr_perr  <= 1'b0;
            wr_ferr  <= 1'b0;
            wr_brk   <= 1'b0;
            overrun  <= 1'b0;
            stop_mid <= 1'b0;
        end else begin
            wr_stb   <= 1'b0;
            overrun  <= 1'b0;
            stop_mid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (tick && !line) state <= ST_START;
                end
                ST_START: begin
                    if (samp) begin
                        if (line) begin
                            state <= ST_IDLE;
                        end else begin
                            state    <= ST_DATA;
                            bidx     <= '0;
                            shreg    <= '0;
                            par_bit  <= 1'b0;
                            all_low  <= 1'b1;
                            ferr_acc <= 1'b0;
                            stop_idx <= 1'b0;
                        end
                    end
                end
                ST_DATA: begin
                    if (samp) begin
                        shreg[bidx] <= line;
                        all_low     <= low_n;
                        if (last_data) state <= par_cfg[0] ? ST_PAR : ST_STOP;
                        else           bidx  <= bidx + 3'd1;
                    end
                end
                ST_PAR: begin
                    if (samp) begin
                        par_bit <= line;
                        all_low <= low_n;
                        state   <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (samp) begin
                        if (last_stop) begin
                            stop_mid <= 1'b1;
                            if (fifo_full) begin
                                overrun <= 1'b1;
                            end else begin
                                wr_stb  <= 1'b1;
                                wr_data <= shreg;
                                wr_perr <= perr_n;
                                wr_ferr <= ferr_n;
                                wr_brk  <= low_n;
                            end
                            state <= low_n ? ST_BRKW : ST_IDLE;
                        end else begin
                            stop_idx <= 1'b1;
                            ferr_acc <= ferr_n;
                            all_low  <= low_n;
                        end
                    end
                end
                ST_BRKW: begin
                    if (tick && line) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2
    false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && samp && line) |=> (state == ST_IDLE));

    // R9
    ovr_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(fifo_full));

    // R9
    ovr_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !wr_stb);

    // R8
    brk_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_brk) |-> (wr_ferr && wr_data == '0));

    // R10
    stop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mid |=> !stop_mid);

    // R8
    brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRKW && !line) |=> (state == ST_BRKW));

endmodule

// File: rtl/uart_rx_deframer.sv
// Top of the receive deframer: line input stage, oversample timer and
// frame state machine. Assumes tick16 is a one-cycle enable at OS_RATE
// times the bit rate and the format inputs change only between frames.
module uart_rx_deframer #(
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rx_pin,
    input  logic       loop_tx,
    input  logic       loop_en,
    input  logic [1:0] word_len,
    input  logic       stop_sel,
    input  logic [2:0] par_cfg,
    input  logic       fifo_full,
    output logic       wr_stb,
    output logic [7:0] wr_data,
    output logic       wr_perr,
    output logic       wr_ferr,
    output logic       wr_brk,
    output logic       overrun,
    output logic       stop_mid
);

    logic line_s;
    logic samp;
    logic t_hold;
    logic t_half;

    rxdf_line_in #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_pin    (rx_pin),
        .loop_tx   (loop_tx),
        .loop_en   (loop_en),
        .line_sync (line_s)
    );

    rxdf_bit_timer #(.OS_RATE(OS_RATE)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .hold     (t_hold),
        .half_sel (t_half),
        .sample   (samp)
    );

    rxdf_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .line       (line_s),
        .samp       (samp),
        .word_len   (word_len),
        .stop_sel   (stop_sel),
        .par_cfg    (par_cfg),
        .fifo_full  (fifo_full),
        .timer_hold (t_hold),
        .timer_half (t_half),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .wr_perr    (wr_perr),
        .wr_ferr    (wr_ferr),
        .wr_brk     (wr_brk),
        .overrun    (overrun),
        .stop_mid   (stop_mid)
    );

endmodule

// File: tb/test_uart_rx_deframer.sv
`timescale 1ns/1ps
module test_uart_rx_deframer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick16;
    logic       line;
    logic       use_loop;
    logic [1:0] word_len;
    logic       stop_sel;
    logic [2:0] par_cfg;
    logic       fifo_full;
    logic       wr_stb, wr_perr, wr_ferr, wr_brk, overrun, stop_mid;
    logic [7:0] wr_data;
    wire        rx_pin  = use_loop ? 1'b0 : line;
    wire        loop_tx = use_loop ? line : 1'b1;

    always #2.5 clk = ~clk;

    uart_rx_deframer i_uart_rx_deframer (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_pin(rx_pin),
        .loop_tx(loop_tx), .loop_en(use_loop), .word_len(word_len),
        .stop_sel(stop_sel), .par_cfg(par_cfg), .fifo_full(fifo_full),
        .wr_stb(wr_stb), .wr_data(wr_data), .wr_perr(wr_perr),
        .wr_ferr(wr_ferr), .wr_brk(wr_brk), .overrun(overrun),
        .stop_mid(stop_mid)
    );

    int    cyc = 0;
    int    vectors = 0;
    int    miscompares = 0;
    string req = "R1";
    // packed expectation: [12] overrun, [10] brk, [9] ferr, [8] perr, [7:0] data
    logic [12:0] expq [int];

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    task automatic cmp(string tag, string fld, int got, int exp);
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s %s cycle %0d got %0d expected %0d", tag, fld, cyc, got, exp);
        end
    endtask

    // Compare every output against the model for the edge just passed.
    task automatic check();
        logic        has;
        logic [12:0] e;
        has = expq.exists(cyc);
        e   = has ? expq[cyc] : 13'd0;
        vectors++;
        cmp(req,   "wr_stb",   int'(wr_stb),   int'(has && !e[12]));
        cmp("R9",  "overrun",  int'(overrun),  int'(has && e[12]));
        cmp("R10", "stop_mid", int'(stop_mid), int'(has));
        if (has && !e[12]) begin
            cmp("R3", "wr_data", int'(wr_data), int'(e[7:0]));
            cmp("R6", "wr_perr", int'(wr_perr), int'(e[8]));
            cmp("R7", "wr_ferr", int'(wr_ferr), int'(e[9]));
            cmp("R8", "wr_brk",  int'(wr_brk),  int'(e[10]));
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        check();
    endtask

    function automatic logic par_exp(logic [7:0] d, logic [2:0] cfg);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += d[i];
        if (cfg[2]) return !cfg[1];
        if (cfg[1]) return (ones % 2) == 1;
        return (ones % 2) == 0;
    endfunction

    // Drive one frame of 16-cycle bits and record its expected outcome.
    task automatic send_frame(logic [7:0] d, logic flip_par,
                              logic [1:0] stop_bad, int stall_bit);
        int         n    = 5 + int'(word_len);
        logic       pen  = par_cfg[0];
        int         schk = (stop_sel && n != 5) ? 2 : 1;
        logic [7:0] dm   = d & 8'((1 << n) - 1);
        logic       pb   = par_exp(dm, par_cfg) ^ flip_par;
        logic       fe   = stop_bad[0] || (schk == 2 && stop_bad[1]);
        logic       lo   = (dm == 0) && (!pen || !pb) && stop_bad[0] &&
                           (schk == 1 || stop_bad[1]);
        int         m    = n + int'(pen) + schk;
        int         k    = cyc + 1;
        int         e    = k + 10 + 16 * m + ((stall_bit >= 0) ? 30 : 0);
        logic       q[$];
        q.push_back(1'b0);
        for (int i = 0; i < n; i++) q.push_back(dm[i]);
        if (pen) q.push_back(pb);
        q.push_back(!stop_bad[0]);
        q.push_back(!stop_bad[1]);
        expq[e] = {fifo_full, 1'b0, lo, fe, pen && flip_par, dm};
        for (int i = 0; i < q.size(); i++) begin
            line = q[i];
            if (i == stall_bit) begin
                tick16 = 1'b0;
                repeat (30) step();
                tick16 = 1'b1;
            end
            repeat (16) step();
        end
        line = 1'b1;
        repeat (40) step();
    endtask

    // Hold the line low for low_len cycles: one break character expected.
    task automatic send_break(int low_len);
        int n    = 5 + int'(word_len);
        int schk = (stop_sel && n != 5) ? 2 : 1;
        int m    = n + int'(par_cfg[0]) + schk;
        int k    = cyc + 1;
        expq[k + 10 + 16 * m] = {fifo_full, 1'b0, 1'b1, 1'b1,
                                 par_cfg[0] && par_exp(8'h00, par_cfg), 8'h00};
        line = 1'b0;
        repeat (low_len) step();
        line = 1'b1;
        repeat (48) step();
    endtask

    initial begin
        #1ms;
        miscompares++;
        $display("FAIL R12 watchdog expired at cycle %0d", cyc);
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick16 = 1'b1; line = 1'b1; use_loop = 1'b0;
        word_len = 2'b11; stop_sel = 1'b0; par_cfg = 3'b000; fifo_full = 1'b0;
        // R1 reset state and quiet idle
        repeat (5) step();
        rst_n = 1'b1;
        repeat (20) step();

        // R3 R4 data order and each width code
        req = "R4";
        send_frame(8'hA5, 1'b0, 2'b00, -1);
        send_frame(8'h3C, 1'b0, 2'b00, -1);
        word_len = 2'b00; send_frame(8'hF5, 1'b0, 2'b00, -1);
        word_len = 2'b01; send_frame(8'h2A, 1'b0, 2'b00, -1);
        word_len = 2'b10; send_frame(8'h55, 1'b0, 2'b00, -1);
        word_len = 2'b11;

        // R6 parity modes, good and corrupted
        req = "R6";
        par_cfg = 3'b001; send_frame(8'h07, 1'b0, 2'b00, -1);
        send_frame(8'h07, 1'b1, 2'b00, -1);
        par_cfg = 3'b011; send_frame(8'h07, 1'b0, 2'b00, -1);
        send_frame(8'h81, 1'b1, 2'b00, -1);
        par_cfg = 3'b101; send_frame(8'h00, 1'b0, 2'b00, -1);
        send_frame(8'h12, 1'b1, 2'b00, -1);
        par_cfg = 3'b111; send_frame(8'hFF, 1'b0, 2'b00, -1);
        send_frame(8'hFF, 1'b1, 2'b00, -1);
        par_cfg = 3'b000;

        // R5 stop-bit selection: 1.5 for 5 bits, 2 otherwise
        req = "R5";
        stop_sel = 1'b1;
        word_len = 2'b00; send_frame(8'h0A, 1'b0, 2'b00, -1);
        word_len = 2'b10; send_frame(8'h33, 1'b0, 2'b00, -1);
        // R7 second stop low is checked with two stops
        req = "R7";
        send_frame(8'h33, 1'b0, 2'b10, -1);
        stop_sel = 1'b0; word_len = 2'b11;
        send_frame(8'hC3, 1'b0, 2'b01, -1);

        // R2 short low glitch, then a normal frame
        req = "R2";
        line = 1'b0; repeat (4) step();
        line = 1'b1; repeat (40) step();
        send_frame(8'h5A, 1'b0, 2'b00, -1);

        // R8 break: one entry, then normal reception resumes
        req = "R8";
        par_cfg = 3'b011; send_break(600);
        send_frame(8'h69, 1'b0, 2'b00, -1);
        par_cfg = 3'b101; send_break(400);
        par_cfg = 3'b000;

        // R9 overrun while full, then a normal write
        req = "R9";
        fifo_full = 1'b1; send_frame(8'hE7, 1'b0, 2'b00, -1);
        fifo_full = 1'b0; send_frame(8'h18, 1'b0, 2'b00, -1);

        // R11 loopback: pin held low must have no effect
        req = "R11";
        use_loop = 1'b1; repeat (40) step();
        send_frame(8'h96, 1'b0, 2'b00, -1);
        use_loop = 1'b0; repeat (20) step();

        // R12 tick enable stalled mid-frame shifts completion
        req = "R12";
        send_frame(8'hB4, 1'b0, 2'b00, 3);

        repeat (30) step();
        summary();
        $finish;
    end

endmodule